// File: doc/BRIEF.md
# Serial LED Pattern Serializer

This block holds a packed vector of drive-status LED bits, three per drive port, and sends the whole vector to an external LED controller over a three-wire serial link. The three wires are a serial clock, a load strobe and a data line. A host posts a status message for one port through a valid/ready stream. The block decodes three LED states from the message, writes them into that port's slot of the vector, and then sends one complete frame. A frame has a run of idle clocks, one clock with the load strobe high, one clock per data bit, and a second run of idle clocks.

Each port writes to a slot chosen by a port-to-slot table, so board wiring order can differ from port numbering. The table, the number of active ports and the two idle-clock counts are plain configuration inputs. The block samples them only at the start of a frame. The serial clock is derived from the system clock by a prescaler, and each of its halves lasts `HALF_CYC` system cycles (50 µs at the default setting and a 200 MHz clock).

Back-pressure: `msg_ready` is high whenever the one-entry message holding register is empty. A message transfers on a cycle where `msg_valid` and `msg_ready` are both high. While a frame is running, one further message can be accepted and held. After that, `msg_ready` stays low until the held message starts its own frame.

Top module: `led_serial_tx`

## Requirements
- R1: After reset, `sgp_clk`, `sgp_load` and `sgp_data` are all high, `busy` is low and `msg_ready` is high.
- R2: Message decoding sets three LED bits. Activity is set if bit 20 or bit 21 of `msg_data` is set. Locate is set if bit 19 is set. Fault is set if bit 22 is set. Each bit is cleared when its source bits are all zero.
- R3: For a message on port p, the three bits land at pattern bits 3·s (activity), 3·s+1 (locate) and 3·s+2 (fault), where s is `cfg_slot_map[3p+2:3p]`. No other pattern bit changes.
- R4: A message whose `msg_data[15:8]` is 15 or more is accepted by the handshake and then discarded. It starts no frame and leaves the pattern unchanged. A value of 14 is accepted normally.
- R5: A frame has `cfg_pre_clks` serial clock cycles with load low, then exactly one cycle with load high, then 3·`cfg_nports` data cycles, then `cfg_post_clks` cycles with load low.
- R6: Data cycle i carries pattern bit i, starting from bit 0. `sgp_data` and `sgp_load` never change while `sgp_clk` is high inside a frame.
- R7: Every serial clock cycle is high for `HALF_CYC` system cycles and then low for `HALF_CYC` system cycles.
- R8: `busy` rises on the clock edge after a frame is started. It stays high for exactly 2·`HALF_CYC` system cycles per serial clock cycle of the frame.
- R9: The holding register takes one message while a frame runs, and `msg_ready` is low while it is full. The held message starts its frame on the first cycle `busy` is low, so `busy` is low for exactly one cycle between the two frames.
- R10: Configuration inputs are sampled only when a frame starts. Changing them during a frame does not affect that frame.
- R11: When a frame ends, `sgp_clk` and `sgp_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Holding register empty; message can be taken |
| msg_port | input | PORT_W | Port the message refers to |
| msg_data | input | 32 | LED message word |
| cfg_slot_map | input | NPORTS·PORT_W | Slot number for each port, port p at bits [PORT_W·p +: PORT_W] |
| cfg_nports | input | NP_W | Number of ports sent per frame |
| cfg_pre_clks | input | CLK_CNT_W | Idle clocks before the load cycle |
| cfg_post_clks | input | CLK_CNT_W | Idle clocks after the data bits |
| sgp_clk | output | 1 | Serial clock line |
| sgp_load | output | 1 | Load strobe line |
| sgp_data | output | 1 | Serial data line |
| busy | output | 1 | Frame in progress |

## Verification
Three events can fall in the same cycle: a frame finishing, a held message being released into the next frame, and new configuration values arriving. The bench provokes this by posting a second message while the first frame is still running, checking that a third is stalled, and changing the pre-clock count mid-frame. It then checks three things: `busy` drops for a single cycle, the first frame kept its original framing, and the second frame uses the new count and carries the held message's bits.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  // activity sits in the LSB of the packed triple
  typedef struct packed {
    logic fault;
    logic locate;
    logic act;
  } led_bits_t;

  localparam logic [31:0] ACT_MASK = 32'h0030_0000;
  localparam logic [31:0] LOC_MASK = 32'h0008_0000;
  localparam logic [31:0] FLT_MASK = 32'h0040_0000;
endpackage

// File: rtl/led_msg_decode.sv
module led_msg_decode
  import led_ser_pkg::*;
#(
  parameter int MSG_SLOTS = 15
) (
  input  logic [31:0] msg,
  output led_bits_t   bits,
  output logic        reject
);
  logic unused_msg;

  always_comb begin
    bits.act    = |(msg & ACT_MASK);
    bits.locate = |(msg & LOC_MASK);
    bits.fault  = |(msg & FLT_MASK);
    reject      = msg[15:8] >= 8'(MSG_SLOTS);
  end

  assign unused_msg = ^{msg[31:23], msg[18:16], msg[7:0]};
endmodule

// File: rtl/led_half_timer.sv
module led_half_timer #(
  parameter int HALF_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq #(
  parameter int NPORTS    = 8,
  parameter int CLK_CNT_W = 4,
  localparam int PW   = 3 * NPORTS,
  localparam int NP_W = $clog2(NPORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 tick,
  input  logic [CLK_CNT_W-1:0] cfg_pre,
  input  logic [CLK_CNT_W-1:0] cfg_post,
  input  logic [NP_W-1:0]      cfg_nports,
  input  logic [PW-1:0]        pattern,
  output logic                 sclk,
  output logic                 sload,
  output logic                 sdata,
  output logic                 busy
);
  localparam int IDX_W = $clog2(2 * (1 << CLK_CNT_W) + PW + 2) + 1;

  logic [IDX_W-1:0]     idx, last_idx, nxt, bit_off, data_end;
  logic [CLK_CNT_W-1:0] pre_q, post_q;
  logic [NP_W-1:0]      n_q;
  logic                 phase_hi, nxt_load, nxt_is_data, nxt_bit;

  always_comb begin
    data_end    = IDX_W'(pre_q) + IDX_W'(3) * IDX_W'(n_q);
    last_idx    = data_end + IDX_W'(post_q);
    nxt         = idx + 1'b1;
    nxt_load    = nxt == IDX_W'(pre_q);
    nxt_is_data = (nxt > IDX_W'(pre_q)) && (nxt <= data_end);
    bit_off     = nxt - IDX_W'(pre_q) - 1'b1;
    nxt_bit     = 1'b0;
    for (int i = 0; i < PW; i++)
      if (bit_off == IDX_W'(i)) nxt_bit = pattern[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b1; sload <= 1'b1; sdata <= 1'b1;
      busy <= 1'b0; phase_hi <= 1'b0; idx <= '0;
      pre_q <= '0; post_q <= '0; n_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        pre_q    <= cfg_pre;
        post_q   <= cfg_post;
        n_q      <= cfg_nports;
        idx      <= '0;
        phase_hi <= 1'b1;
        sclk     <= 1'b1;
        sload    <= (cfg_pre == '0);
      end
    end else if (tick) begin
      if (phase_hi) begin
        phase_hi <= 1'b0;
        sclk     <= 1'b0;
        if (idx == last_idx) sload <= 1'b0;
        else begin
          sload <= nxt_load;
          if (nxt_is_data) sdata <= nxt_bit;
        end
      end else if (idx == last_idx) begin
        busy <= 1'b0;
      end else begin
        idx      <= nxt;
        phase_hi <= 1'b1;
        sclk     <= 1'b1;
      end
    end
  end

  // lines only move on a falling serial clock
  p_lines_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk && $past(sclk)) |-> ($stable(sdata) && $stable(sload)));
  // serial clock moves only on a prescaler tick
  p_sclk_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));
  // frame end leaves clock and load low
  p_end_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sclk && !sload));
endmodule

// File: rtl/led_serial_tx.sv
module led_serial_tx
  import led_ser_pkg::*;
#(
  parameter int NPORTS    = 8,
  parameter int MSG_SLOTS = 15,
  parameter int CLK_CNT_W = 4,
  parameter int HALF_CYC  = 10000,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int NP_W   = $clog2(NPORTS + 1),
  localparam int PW     = 3 * NPORTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msg_valid,
  output logic                     msg_ready,
  input  logic [PORT_W-1:0]        msg_port,
  input  logic [31:0]              msg_data,
  input  logic [NPORTS*PORT_W-1:0] cfg_slot_map,
  input  logic [NP_W-1:0]          cfg_nports,
  input  logic [CLK_CNT_W-1:0]     cfg_pre_clks,
  input  logic [CLK_CNT_W-1:0]     cfg_post_clks,
  output logic                     sgp_clk,
  output logic                     sgp_load,
  output logic                     sgp_data,
  output logic                     busy
);
  led_bits_t         dec_bits, pend_bits;
  logic              dec_reject, accept, start, tick, pend_valid;
  logic [PORT_W-1:0] pend_port, sel_slot;
  logic [PW-1:0]     pattern;

  led_msg_decode #(.MSG_SLOTS(MSG_SLOTS)) u_dec (
    .msg(msg_data), .bits(dec_bits), .reject(dec_reject));

  assign msg_ready = !pend_valid;
  assign accept    = msg_valid && msg_ready;
  assign start     = pend_valid && !busy;
  assign sel_slot  = cfg_slot_map[int'(pend_port) * PORT_W +: PORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_port  <= '0;
      pend_bits  <= '0;
    end else if (start) begin
      pend_valid <= 1'b0;
    end else if (accept && !dec_reject) begin
      pend_valid <= 1'b1;
      pend_port  <= msg_port;
      pend_bits  <= dec_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pattern <= '0;
    else if (start)
      for (int s = 0; s < NPORTS; s++)
        if (sel_slot == PORT_W'(s)) pattern[3*s +: 3] <= pend_bits;
  end

  led_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick));

  led_frame_seq #(.NPORTS(NPORTS), .CLK_CNT_W(CLK_CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .cfg_pre(cfg_pre_clks), .cfg_post(cfg_post_clks), .cfg_nports(cfg_nports),
    .pattern(pattern), .sclk(sgp_clk), .sload(sgp_load), .sdata(sgp_data),
    .busy(busy));

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_reject_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_reject) |=> !pend_valid);
  p_held_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && busy) |=> (pend_valid && $stable(pend_bits) && $stable(pend_port)));
endmodule

// File: tb/tb_led_serial_tx.sv
`timescale 1ns/1ps
module tb_led_serial_tx;
  localparam int NPORTS = 8, PORT_W = 3, NP_W = 4, CW = 4, HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_ready;
  logic [PORT_W-1:0] msg_port = '0;
  logic [31:0] msg_data = '0;
  logic [NPORTS*PORT_W-1:0] cfg_slot_map;
  logic [NP_W-1:0] cfg_nports = 4'd2;
  logic [CW-1:0] cfg_pre_clks = 4'd1, cfg_post_clks = 4'd1;
  logic sgp_clk, sgp_load, sgp_data, busy;

  always #2.5 clk = ~clk;

  led_serial_tx #(.NPORTS(NPORTS), .MSG_SLOTS(15), .CLK_CNT_W(CW), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_port(msg_port), .msg_data(msg_data), .cfg_slot_map(cfg_slot_map),
    .cfg_nports(cfg_nports), .cfg_pre_clks(cfg_pre_clks), .cfg_post_clks(cfg_post_clks),
    .sgp_clk(sgp_clk), .sgp_load(sgp_load), .sgp_data(sgp_data), .busy(busy));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cap_cyc, cap_werr, cap_serr, cap_blen, cap_idle;
  logic [63:0] cap_load, cap_data;

  // port,msg,expected low six pattern bits (port0 -> slot1, port1 -> slot0)
  localparam logic [40:0] VEC [7] = '{
    {3'd0, 32'h0030_0000, 6'h08},
    {3'd1, 32'h0008_0000, 6'h0A},
    {3'd0, 32'h0040_0000, 6'h22},
    {3'd1, 32'h0010_0000, 6'h21},
    {3'd0, 32'h0078_0000, 6'h39},
    {3'd1, 32'h0000_0E00, 6'h38},
    {3'd0, 32'h0020_0000, 6'h08}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [PORT_W-1:0] p, input logic [31:0] m);
    @(negedge clk);
    msg_port = p; msg_data = m; msg_valid = 1'b1;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic capture();
    int hc;
    logic lh, dh;
    cap_cyc = 0; cap_werr = 0; cap_serr = 0; cap_blen = 0; cap_idle = 0;
    cap_load = '0; cap_data = '0; hc = 0; lh = 0; dh = 0;
    @(negedge clk);
    while (!busy && cap_idle < 60) begin cap_idle++; @(negedge clk); end
    while (busy) begin
      cap_blen++;
      if (sgp_clk) begin
        if (hc > 0 && (sgp_data !== dh || sgp_load !== lh)) cap_serr++;
        dh = sgp_data; lh = sgp_load; hc++;
      end else if (hc > 0) begin
        cap_load[cap_cyc] = lh; cap_data[cap_cyc] = dh;
        if (hc != HALF) cap_werr++;
        cap_cyc++; hc = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input string tag, input int pre, input int n, input int post,
                             input logic [63:0] bits);
    chk({tag, " R5 cycle count"}, 64'(cap_cyc), 64'(pre + 1 + 3*n + post));
    chk({tag, " R5 load position"}, cap_load, 64'(1) << pre);
    chk({tag, " R6 data bits"}, (cap_data >> (pre + 1)) & ((64'(1) << (3*n)) - 1), bits);
    chk({tag, " R7 half widths"}, 64'(cap_werr), 64'd0);
    chk({tag, " R6 stable while high"}, 64'(cap_serr), 64'd0);
    chk({tag, " R8 busy length"}, 64'(cap_blen), 64'(2 * HALF * cap_cyc));
    chk({tag, " R11 lines low after frame"}, {62'd0, sgp_clk, sgp_load}, 64'd0);
  endtask

  initial begin
    for (int p = 0; p < NPORTS; p++)
      cfg_slot_map[p*PORT_W +: PORT_W] = (p == 0) ? 3'd1 : (p == 1) ? 3'd0 : PORT_W'(p);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset lines", {60'd0, sgp_clk, sgp_load, sgp_data, busy}, 64'hE);
    chk("R1 reset ready", {63'd0, msg_ready}, 64'd1);

    // R2 R3 table walk
    for (int v = 0; v < 7; v++) begin
      send(VEC[v][40:38], VEC[v][37:6]);
      capture();
      check_frame($sformatf("R2 R3 vec%0d", v), 1, 2, 1, 64'(VEC[v][5:0]));
    end

    // R4 out-of-range slot field: no frame
    begin
      int seen = 0;
      send(3'd1, 32'h0040_0F00);
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy) seen++; end
      chk("R4 rejected message starts no frame", 64'(seen), 64'd0);
    end
    send(3'd0, 32'h0);
    capture();
    check_frame("R4 pattern untouched", 1, 2, 1, 64'h00);

    // R3 port beyond active count, then widen the frame
    send(3'd2, 32'h0040_0000);
    capture();
    check_frame("R3 slot2 hidden at n=2", 1, 2, 1, 64'h00);
    cfg_nports = 4'd3;
    send(3'd2, 32'h0040_0000);
    capture();
    check_frame("R3 slot2 visible at n=3", 1, 3, 1, 64'h100);

    // R5 zero idle clocks
    cfg_pre_clks = 4'd0; cfg_post_clks = 4'd0;
    send(3'd1, 32'h0008_0000);
    capture();
    check_frame("R5 no idle clocks", 0, 3, 0, 64'h102);

    // R9 R10 held message, stalled third, mid-frame config change
    cfg_pre_clks = 4'd2; cfg_post_clks = 4'd1; cfg_nports = 4'd2;
    fork
      begin
        send(3'd0, 32'h0020_0000);
        send(3'd1, 32'h0);
        msg_port = 3'd2; msg_data = 32'h0040_0000; msg_valid = 1'b1;
        #0.1;
        chk("R9 ready low while held", {63'd0, msg_ready}, 64'd0);
        cfg_pre_clks = 4'd5;
        @(negedge clk);
        msg_valid = 1'b0;
      end
      capture();
    join
    check_frame("R10 frame A keeps old config", 2, 2, 1, 64'h0A);
    capture();
    chk("R9 one idle cycle between frames", 64'(cap_idle), 64'd0);
    check_frame("R9 held frame B", 5, 2, 1, 64'h08);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule